// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Power-Up Blanking

This block collects interrupt requests for a USB bridge device and drives one interrupt line to the host processor. Three secondary groups (USB core, DMA and GPIO) each keep a 32-bit pending register. Hardware events and software writes can set bits in it, software writes can clear bits in it, and a mask register sits beside it. The unmasked pending bits of the USB core and DMA groups are reduced into summary bits of a 32-bit top-level pending register. That register also accepts direct level events, software set and software clear.

The unmasked top-level bits are ORed together and drive the interrupt line. A configuration bit selects the line's polarity. After power is applied, the line is held inactive for a programmable number of clock cycles. Every register sits on a simple 32-bit register bus with a combinational read port. Each group occupies one 16-byte page, with four words: source, set, clear and mask.

Top module: `irq_hier_agg`

## Requirements
- R1: After reset the top-level pending register is 0 and the top-level mask is all ones. Every group pending register and every group mask is 0, the configuration word is 0 and the line is 0.
- R2: Page codes (address bits 7:4) are 0 for top level, 1 for USB, 2 for DMA and 3 for GPIO. Within a page, word 0 is source, word 1 is set, word 2 is clear and word 3 is mask. A set write ORs the data into the pending register, and a clear write clears every bit written as 1. Reads of the source, set and clear words all return the current pending value.
- R3: A mask write replaces the whole mask. Any write that changes pending or mask state is reflected on the line in the cycle after the write.
- R4: Top-level bit 9 is 1 exactly when some unmasked USB pending bit in 15:0 is set. Top-level bit 8 is 1 exactly when some unmasked USB pending bit in 31:16 is set.
- R5: Top-level bit 24 is 1 exactly when some unmasked DMA pending bit is set.
- R6: GPIO pending bits never change the top-level register or the line.
- R7: Bit 17 of the configuration word (address 0x40) is the polarity. When it is 1 the line is the OR of the unmasked top-level bits. When it is 0 the line is the inverse of that OR.
- R8: The line is 0 from reset until power first comes up. On each rising edge of `pwr_on` the line is forced to 0 for BLANK_CYCLES clock edges and is released on the next edge. Dropping power during the window cancels the release. Dropping power after the release does not gate the line again.
- R9: When `evt_stb[n]` is 1, top-level bit n takes the value `evt_lvl[n]`. This hardware update wins over a software clear of the same bit in the same cycle. A group hardware set likewise wins over a same-cycle group clear.
- R10: Address 0x44 reads the constant 0x20. Unmapped addresses read 0 and ignore writes.
- R11: Software set and clear writes and direct events have no effect on top-level bits 8, 9 and 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Power-good level; a rising edge starts the blanking window |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_stb | input | 32 | Per-bit strobe for direct top-level events |
| evt_lvl | input | 32 | Level loaded into strobed top-level bits |
| usb_hw_set | input | 32 | USB core event pulses, ORed into the USB group |
| dma_hw_set | input | 32 | DMA event pulses, ORed into the DMA group |
| gpio_hw_set | input | 32 | GPIO event pulses, ORed into the GPIO group |
| irq_line | output | 1 | Interrupt line to the host |

## Verification
The properties check the following on every cycle: the line stays low whenever the blanking gate is closed and just after each power rise, top-level set, clear and mask writes land one cycle later, and a strobed event loads its level. Some behaviour only shows across a stimulus sequence, so the directed and random scenarios check it. This covers the split of USB pending bits into two summaries, the isolation of the GPIO group, a cancelled power window, and the priority of hardware over a same-cycle clear. The bench compares each result against a software model of all pending and mask state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int NUM_GROUPS = 3;
    localparam int HALF_W     = DATA_W / 2;

    // page codes in address bits 7:4
    localparam logic [3:0] PAGE_TOP  = 4'd0;
    localparam logic [3:0] PAGE_USB  = 4'd1;
    localparam logic [3:0] PAGE_DMA  = 4'd2;
    localparam logic [3:0] PAGE_GPIO = 4'd3;
    localparam logic [3:0] PAGE_CTL  = 4'd4;

    localparam int GRP_USB = 0;
    localparam int GRP_DMA = 1;

    typedef enum logic [1:0] {
        REG_SRC  = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_MASK = 2'd3
    } grp_reg_e;

    localparam logic [ADDR_W-1:0] ADDR_TOP_SET  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_TOP_CLR  = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_TOP_MASK = 8'h0C;

    localparam int BIT_USB_RX = 8;
    localparam int BIT_USB_TX = 9;
    localparam int BIT_DMA    = 24;
    localparam int POL_BIT    = 17;

    localparam logic [DATA_W-1:0] SUMMARY_BITS =
        (DATA_W'(1) << BIT_USB_RX) | (DATA_W'(1) << BIT_USB_TX) | (DATA_W'(1) << BIT_DMA);
    localparam logic [DATA_W-1:0] REV_VALUE = 32'h0000_0020;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] cfg;
    } top_state_t;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] src,
    output logic [W-1:0] mask
);
    typedef struct packed {
        logic [W-1:0] src;
        logic [W-1:0] mask;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_set)  st_d.src  = st_d.src | wdata;
        if (wr_clr)  st_d.src  = st_d.src & ~wdata;
        if (wr_mask) st_d.mask = wdata;
        // hardware events win over a same-cycle software clear
        st_d.src = st_d.src | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src  = st_q.src;
    assign mask = st_q.mask;
endmodule

// File: rtl/irq_blank_timer.sv
module irq_blank_timer #(
    parameter int unsigned BLANK_CYCLES = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    output logic gate_ok
);
    localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYCLES - 1);

    typedef struct packed {
        logic             pwr;
        logic             win;
        logic             ok;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwr = pwr_on;
        if (pwr_on && !st_q.pwr) begin
            st_d.ok  = 1'b0;
            st_d.win = 1'b1;
            st_d.cnt = LOAD;
        end else if (st_q.win) begin
            if (!pwr_on) begin
                st_d.win = 1'b0;
            end else if (st_q.cnt == '0) begin
                st_d.ok  = 1'b1;
                st_d.win = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_ok = st_q.ok;
endmodule

// File: rtl/irq_hier_agg.sv
module irq_hier_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 30_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt_stb,
    input  logic [DATA_W-1:0] evt_lvl,
    input  logic [DATA_W-1:0] usb_hw_set,
    input  logic [DATA_W-1:0] dma_hw_set,
    input  logic [DATA_W-1:0] gpio_hw_set,
    output logic              irq_line
);
    logic [3:0]  page;
    grp_reg_e    sel;
    logic        word_ok;
    assign page    = bus_addr[7:4];
    assign sel     = grp_reg_e'(bus_addr[3:2]);
    assign word_ok = (bus_addr[1:0] == 2'b00);

    logic [DATA_W-1:0] hw_arr   [NUM_GROUPS];
    logic [DATA_W-1:0] grp_src  [NUM_GROUPS];
    logic [DATA_W-1:0] grp_mask [NUM_GROUPS];
    assign hw_arr[0] = usb_hw_set;
    assign hw_arr[1] = dma_hw_set;
    assign hw_arr[2] = gpio_hw_set;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = bus_wr && word_ok && (page == 4'(g + 1));
        irq_group #(.W(DATA_W)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_set  (hit && sel == REG_SET),
            .wr_clr  (hit && sel == REG_CLR),
            .wr_mask (hit && sel == REG_MASK),
            .wdata   (bus_wdata),
            .hw_set  (hw_arr[g]),
            .src     (grp_src[g]),
            .mask    (grp_mask[g])
        );
    end

    logic gate_ok;
    irq_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_on  (pwr_on),
        .gate_ok (gate_ok)
    );

    top_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr && word_ok && page == PAGE_TOP) begin
            case (sel)
                REG_SET:  st_d.src  = st_d.src | bus_wdata;
                REG_CLR:  st_d.src  = st_d.src & ~bus_wdata;
                REG_MASK: st_d.mask = bus_wdata;
                default:  ;
            endcase
        end
        if (bus_wr && word_ok && page == PAGE_CTL && bus_addr[3:2] == 2'd0)
            st_d.cfg = bus_wdata;
        // direct level events, applied after software so they win
        st_d.src = (st_d.src & ~evt_stb) | (evt_lvl & evt_stb);
        // summary positions are derived, never stored
        st_d.src = st_d.src & ~SUMMARY_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src  <= '0;
            st_q.mask <= '1;
            st_q.cfg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [DATA_W-1:0] usb_pend, dma_pend;
    assign usb_pend = grp_src[GRP_USB] & ~grp_mask[GRP_USB];
    assign dma_pend = grp_src[GRP_DMA] & ~grp_mask[GRP_DMA];

    logic [DATA_W-1:0] src_eff;
    always_comb begin
        src_eff             = st_q.src;
        src_eff[BIT_USB_TX] = |usb_pend[HALF_W-1:0];
        src_eff[BIT_USB_RX] = |usb_pend[DATA_W-1:HALF_W];
        src_eff[BIT_DMA]    = |dma_pend;
    end

    logic [DATA_W-1:0] top_mask;
    logic              any_pend;
    assign top_mask = st_q.mask;
    assign any_pend = |(src_eff & ~st_q.mask);
    assign irq_line = gate_ok & (st_q.cfg[POL_BIT] ? any_pend : ~any_pend);

    always_comb begin
        bus_rdata = '0;
        if (word_ok) begin
            if (page == PAGE_TOP) begin
                bus_rdata = (sel == REG_MASK) ? st_q.mask : src_eff;
            end else if (page == PAGE_CTL) begin
                if (bus_addr[3:2] == 2'd0)      bus_rdata = st_q.cfg;
                else if (bus_addr[3:2] == 2'd1) bus_rdata = REV_VALUE;
            end else begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (page == 4'(g + 1))
                        bus_rdata = (sel == REG_MASK) ? grp_mask[g] : grp_src[g];
                end
            end
        end
    end
endmodule

// File: rtl/irq_hier_agg_chk.sv
module irq_hier_agg_chk
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_on,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] evt_stb,
    input logic [DATA_W-1:0] evt_lvl,
    input logic              irq_line,
    input logic              gate_ok,
    input logic [DATA_W-1:0] src_eff,
    input logic [DATA_W-1:0] top_mask
);
    // R8
    rise_blanks_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |=> !irq_line);

    // R8
    closed_gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_ok |-> !irq_line);

    // R2
    top_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TOP_SET && evt_stb == '0) |=>
        ((src_eff & $past(bus_wdata) & ~SUMMARY_BITS) == ($past(bus_wdata) & ~SUMMARY_BITS)));

    // R2
    top_clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TOP_CLR && evt_stb == '0) |=>
        ((src_eff & $past(bus_wdata) & ~SUMMARY_BITS) == '0));

    // R3
    top_mask_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TOP_MASK) |=> (top_mask == $past(bus_wdata)));

    // R9
    event_loads_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb[0] |=> (src_eff[0] == $past(evt_lvl[0])));
endmodule

bind irq_hier_agg irq_hier_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on    (pwr_on),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_stb   (evt_stb),
    .evt_lvl   (evt_lvl),
    .irq_line  (irq_line),
    .gate_ok   (gate_ok),
    .src_eff   (src_eff),
    .top_mask  (top_mask)
);

// File: tb/test_irq_hier_agg.sv
`timescale 1ns/1ps
module test_irq_hier_agg;
    localparam int N = 20;
    localparam logic [31:0] SUM = 32'h0100_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_on = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] evt_stb = '0, evt_lvl = '0;
    logic [31:0] usb_hw_set = '0, dma_hw_set = '0, gpio_hw_set = '0;
    logic        irq_line;

    always #2.5 clk = ~clk;

    irq_hier_agg #(.BLANK_CYCLES(N)) i_irq_hier_agg (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_stb(evt_stb), .evt_lvl(evt_lvl), .usb_hw_set(usb_hw_set),
        .dma_hw_set(dma_hw_set), .gpio_hw_set(gpio_hw_set), .irq_line(irq_line));

    int checks = 0;
    int errors = 0;

    // reference model
    logic [31:0] m_src, m_mask, m_cfg;
    logic [31:0] m_g [3];
    logic [31:0] m_gm [3];
    logic        m_ok;

    function automatic logic [31:0] exp_src();
        logic [31:0] s;
        logic [31:0] u;
        s = m_src & ~SUM;
        u = m_g[0] & ~m_gm[0];
        s[9]  = |u[15:0];
        s[8]  = |u[31:16];
        s[24] = |(m_g[1] & ~m_gm[1]);
        return s;
    endfunction

    function automatic logic exp_line();
        logic any;
        any = |(exp_src() & ~m_mask);
        return m_ok & (m_cfg[17] ? any : ~any);
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int pg;
        pg = int'(a[7:4]);
        if (pg == 0) begin
            case (a[3:2])
                2'd1: m_src = m_src | d;
                2'd2: m_src = m_src & ~d;
                2'd3: m_mask = d;
                default: ;
            endcase
        end else if (pg >= 1 && pg <= 3) begin
            case (a[3:2])
                2'd1: m_g[pg-1] = m_g[pg-1] | d;
                2'd2: m_g[pg-1] = m_g[pg-1] & ~d;
                2'd3: m_gm[pg-1] = d;
                default: ;
            endcase
        end else if (pg == 4 && a[3:2] == 2'd0) begin
            m_cfg = d;
        end
        m_src = m_src & ~SUM;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] stb, input logic [31:0] lvl,
                       input logic [31:0] uh, input logic [31:0] dh, input logic [31:0] gh);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        evt_stb = stb; evt_lvl = lvl;
        usb_hw_set = uh; dma_hw_set = dh; gpio_hw_set = gh;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        evt_stb = '0; evt_lvl = '0;
        usb_hw_set = '0; dma_hw_set = '0; gpio_hw_set = '0;
        if (wr) model_write(a, d);
        m_src = ((m_src & ~stb) | (lvl & stb)) & ~SUM;
        m_g[0] = m_g[0] | uh;
        m_g[1] = m_g[1] | dh;
        m_g[2] = m_g[2] | gh;
        #0.1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, '0, '0, '0, '0, '0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        check(tag, bus_rdata, exp);
        bus_addr = 8'h00;
    endtask

    task automatic state_chk(input string tag);
        check({tag, " src"}, bus_rdata, exp_src());
        check({tag, " line"}, {31'd0, irq_line}, {31'd0, exp_line()});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] addrs [13];
        void'($urandom(32'd20240611));
        addrs = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h1C, 8'h24, 8'h28,
                  8'h2C, 8'h34, 8'h38, 8'h3C, 8'h40};
        m_src = '0; m_mask = '1; m_cfg = '0; m_ok = 1'b0;
        for (int i = 0; i < 3; i++) begin m_g[i] = '0; m_gm[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 top src", 8'h00, 32'h0);
        rd_chk("R1 top mask", 8'h0C, 32'hFFFF_FFFF);
        rd_chk("R1 usb mask", 8'h1C, 32'h0);
        rd_chk("R1 cfg", 8'h40, 32'h0);
        check("R1 line", {31'd0, irq_line}, 32'h0);
        // R10 constant and holes
        rd_chk("R10 rev", 8'h44, 32'h20);
        rd_chk("R10 hole", 8'h48, 32'h0);
        rd_chk("R10 page5", 8'h50, 32'h0);

        // R8 before any power: pending and active-high, line stays 0
        wr(8'h40, 32'h0002_0000);
        wr(8'h0C, 32'h0);
        wr(8'h04, 32'h1);
        state_chk("R8 unpowered");

        // R8 window
        @(negedge clk); pwr_on = 1'b1;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            check("R8 blanked", {31'd0, irq_line}, 32'h0);
        end
        @(negedge clk);
        m_ok = 1'b1;
        check("R8 released", {31'd0, irq_line}, 32'h1);
        @(negedge clk); pwr_on = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 off keeps line", {31'd0, irq_line}, 32'h1);
        @(negedge clk); pwr_on = 1'b1; m_ok = 1'b0;
        @(negedge clk);
        check("R8 restart blanks", {31'd0, irq_line}, 32'h0);
        repeat (4) @(negedge clk);
        pwr_on = 1'b0;
        repeat (2 * N) @(negedge clk);
        check("R8 cancelled window", {31'd0, irq_line}, 32'h0);
        @(negedge clk); pwr_on = 1'b1;
        repeat (N + 1) @(negedge clk);
        m_ok = 1'b1;
        check("R8 second release", {31'd0, irq_line}, 32'h1);

        // R7 polarity
        wr(8'h40, 32'h0);
        state_chk("R7 low polarity pending");
        wr(8'h08, 32'h1);
        state_chk("R7 low polarity idle");
        wr(8'h40, 32'h0002_0000);
        state_chk("R7 high polarity idle");

        // R4 USB split
        cyc(1'b0, 8'h00, '0, '0, '0, 32'h0000_0008, '0, '0);
        state_chk("R4 tx summary");
        cyc(1'b0, 8'h00, '0, '0, '0, 32'h0010_0000, '0, '0);
        state_chk("R4 rx summary");
        wr(8'h1C, 32'h0000_0008);
        state_chk("R4 tx masked");
        rd_chk("R2 usb set read", 8'h14, m_g[0]);
        rd_chk("R2 usb clr read", 8'h18, m_g[0]);
        wr(8'h18, 32'hFFFF_FFFF);
        state_chk("R4 usb cleared");
        // R5 DMA
        cyc(1'b0, 8'h00, '0, '0, '0, '0, 32'h8000_0000, '0);
        state_chk("R5 dma summary");
        wr(8'h2C, 32'h8000_0000);
        state_chk("R5 dma masked");
        // R6 GPIO isolated
        cyc(1'b0, 8'h00, '0, '0, '0, '0, '0, 32'hFFFF_FFFF);
        state_chk("R6 gpio isolated");
        rd_chk("R6 gpio src", 8'h30, 32'hFFFF_FFFF);
        // R11 summary bits not writable
        wr(8'h04, SUM);
        state_chk("R11 set ignored");
        cyc(1'b0, 8'h00, '0, SUM, SUM, '0, '0, '0);
        state_chk("R11 event ignored");
        // R9 events and priority
        cyc(1'b0, 8'h00, '0, 32'h20, 32'h20, '0, '0, '0);
        state_chk("R9 event set");
        cyc(1'b0, 8'h00, '0, 32'h20, 32'h0, '0, '0, '0);
        state_chk("R9 event clear");
        cyc(1'b1, 8'h08, 32'h20, 32'h20, 32'h20, '0, '0, '0);
        state_chk("R9 event beats clear");
        cyc(1'b1, 8'h18, 32'h4, '0, '0, 32'h4, '0, '0);
        rd_chk("R9 group set beats clear", 8'h10, m_g[0]);
        // R3 mask replace
        wr(8'h0C, 32'hFFFF_FFDF);
        state_chk("R3 mask replace");

        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [31:0] d, stb;
            logic [7:0]  a;
            logic        w;
            a   = addrs[$urandom_range(0, 12)];
            d   = $urandom() & $urandom();
            w   = ($urandom_range(0, 3) != 0);
            stb = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : '0;
            cyc(w, a, d, stb, $urandom(),
                ($urandom_range(0, 4) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0,
                ($urandom_range(0, 4) == 0) ? (32'h1 << $urandom_range(0, 31)) : '0,
                ($urandom_range(0, 4) == 0) ? $urandom() : '0);
            state_chk("R2 R7 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule